// File: doc/BRIEF.md
# SPI Master Frame Engine

This block is a memory-mapped SPI master. Software sets a word length (8 to 32 bits) and a word count, loads the transmit queue, and raises the enable bits in a fixed order. The block then clocks out one frame of that many words on the serial clock and data-out pins. At the same time it samples the data-in pin and stores each received word. When the last word has shifted, it sets end-of-frame status flags, and these can raise an interrupt.

Each queue holds 64 words of 32 bits. Data in the queues is left-justified, so a word of B bits occupies bits 31 down to 32-B. Each control bit that software writes comes back on readback only once the block has applied it. Software should wait for that readback before the next step. Chip select is produced outside the block.

Top module: `spi_frame_master`

## Requirements
- R1: After reset, the control and status readbacks are zero, `irq` is low, `sck` is low and `mosi_oe` is high.
- R2: The format register (address 0) gives the word length minus one in bits 28:24 and the word count minus one in bits 23:16. A length below 8 is treated as 8, and a count above the queue depth is capped at the depth. One frame shifts exactly that many words of that many bits.
- R3: Queue data is left-justified. The transmitted word is taken from bits 31:(32-B). A received word is returned in bits 31:(32-B), with the low bits zero.
- R4: Control register (address 1): bit 15 enables the clock, bit 14 starts the frame, bit 9 enables transmit, bit 8 enables receive, bit 1 is clock polarity and bit 0 is clock phase. A written value appears on the control readback by the second read after the write.
- R5: A frame begins only when the applied frame-start bit rises while the applied clock enable is set. Without the clock enable, `sck` does not toggle and no status is set.
- R6: While idle, `sck` rests at the polarity bit. With phase 0, data is sampled on the first clock edge of each bit. With phase 1, data is sampled on the second edge.
- R7: Format bit 8 set shifts each word least-significant bit first. When the bit is clear, the most-significant bit goes first.
- R8: Format bit 0 makes a receive-only frame: `mosi` stays 0 and the transmit queue is not popped. Format bit 9 (three-wire) lowers `mosi_oe` whenever data is not driven, meaning idle or receive-only. Otherwise `mosi_oe` stays high.
- R9: Status register (address 2): bit 23 is set at frame end when transmit is enabled. Bit 7 is set at frame end only when receive is enabled. Writing ones clears the flags written. A flag that is set in the same cycle as a clearing write stays set.
- R10: `irq` is the OR of the status bits masked by the interrupt-enable register (address 3), which uses the same bit positions.
- R11: A write to address 4 pushes the transmit queue and is dropped when the queue is full. A read of address 5 pops the receive queue. Reading an empty receive queue returns zero and leaves it unchanged. An empty transmit queue supplies zero words.
- R12: Received words enter the receive queue only while receive is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during the access cycle |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Data-out drive enable |
| miso | input | 1 | Serial data in |

## Verification
Two events can land in the same cycle: a software write that clears a status flag, and the frame end that sets the flag. The bench starts a frame and then writes all-ones to the status register on every clock until `irq` rises. Sooner or later the final edge of the frame coincides with one of these clearing writes. The flag must survive that cycle, so the bench judges the collision by seeing `irq` go high and the status readback holding both end-of-frame bits afterwards.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        A_FMT  = 3'd0,
        A_CTRL = 3'd1,
        A_STAT = 3'd2,
        A_IEN  = 3'd3,
        A_TXD  = 3'd4,
        A_RXD  = 3'd5
    } addr_e;

    localparam int C_CLK  = 15;
    localparam int C_FS   = 14;
    localparam int C_TX   = 9;
    localparam int C_RX   = 8;
    localparam int C_CPOL = 1;
    localparam int C_CPHA = 0;

    localparam int S_TEOF = 23;
    localparam int S_REOF = 7;

    localparam int F_MUTE = 0;
    localparam int F_LSB  = 8;
    localparam int F_3W   = 9;

    localparam logic [31:0] CTRL_MASK = 32'h0000_C303;
    localparam logic [31:0] STAT_MASK = 32'h0080_0080;

    typedef struct packed {
        logic [31:0] fmt;
        logic [31:0] ctrl;
        logic [31:0] ack;
        logic [31:0] stat;
        logic [31:0] ien;
    } regs_t;
endpackage

// File: rtl/sfe_fifo.sv
module sfe_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW:0] wp;
        logic [AW:0] rp;
    } ptr_t;

    ptr_t         q, d;
    logic [W-1:0] mem [DEPTH];
    logic         do_push, do_pop;

    assign empty   = (q.wp == q.rp);
    assign full    = (q.wp[AW-1:0] == q.rp[AW-1:0]) && (q.wp[AW] != q.rp[AW]);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[q.rp[AW-1:0]];

    always_comb begin
        d = q;
        if (do_push) d.wp = q.wp + 1'b1;
        if (do_pop)  d.rp = q.rp + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wp[AW-1:0]] <= wdata;
    end

    // R11
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full && push |=> $stable(q.wp));

    // R11
    udf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty && pop |=> $stable(q.rp));
endmodule

// File: rtl/sfe_shift.sv
module sfe_shift #(
    parameter int HALF = 2,
    parameter int MAXW = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clk_en,
    input  logic        fs_en,
    input  logic        tx_en,
    input  logic        rx_en,
    input  logic        cpol,
    input  logic        cpha,
    input  logic        lsb,
    input  logic        mute,
    input  logic [4:0]  wlen_m1,
    input  logic [7:0]  wcnt_m1,
    input  logic [31:0] tx_head,
    input  logic        tx_empty,
    output logic        tx_pop,
    output logic        rx_push,
    output logic [31:0] rx_data,
    input  logic        miso,
    output logic        sck,
    output logic        mosi,
    output logic        busy,
    output logic        done
);
    localparam int          DIVW  = $clog2(HALF + 1);
    localparam logic [8:0]  MAXW9 = 9'(MAXW);

    typedef struct packed {
        logic            busy;
        logic            ph;
        logic            fs_prev;
        logic [DIVW-1:0] div;
        logic [4:0]      bitn;
        logic [7:0]      wordn;
        logic [31:0]     txw;
        logic [31:0]     rxw;
        logic            sck;
        logic            mosi;
    } eng_t;

    eng_t        q, d;
    logic [5:0]  blen;
    logic [8:0]  wcnt, wcnt_raw;
    logic [31:0] next_word;
    logic        use_tx;

    function automatic logic [4:0] pos_of(input logic l, input logic [5:0] n,
                                          input logic [5:0] i);
        return l ? i[4:0] : 5'(n - 6'd1 - i);
    endfunction

    assign blen      = (wlen_m1 < 5'd7) ? 6'd8 : ({1'b0, wlen_m1} + 6'd1);
    assign wcnt_raw  = {1'b0, wcnt_m1} + 9'd1;
    assign wcnt      = (wcnt_raw > MAXW9) ? MAXW9 : wcnt_raw;
    assign use_tx    = tx_en && !mute;
    assign next_word = (use_tx && !tx_empty) ? (tx_head >> (6'd32 - blen)) : 32'd0;

    always_comb begin
        d         = q;
        tx_pop    = 1'b0;
        rx_push   = 1'b0;
        done      = 1'b0;
        d.fs_prev = fs_en;
        if (!q.busy) begin
            d.sck  = cpol;
            d.mosi = 1'b0;
            if (fs_en && !q.fs_prev && clk_en) begin
                d.busy  = 1'b1;
                d.ph    = 1'b0;
                d.div   = '0;
                d.bitn  = '0;
                d.wordn = '0;
                d.txw   = next_word;
                d.rxw   = '0;
                tx_pop  = use_tx && !tx_empty;
                d.mosi  = next_word[pos_of(lsb, blen, 6'd0)];
                d.sck   = cpol ^ cpha;
            end
        end else if (q.div != DIVW'(HALF - 1)) begin
            d.div = q.div + 1'b1;
        end else begin
            d.div = '0;
            if (!q.ph) begin
                d.ph = 1'b1;
                d.rxw[pos_of(lsb, blen, {1'b0, q.bitn})] = miso;
                d.sck = ~(cpol ^ cpha);
            end else begin
                d.ph = 1'b0;
                if ({1'b0, q.bitn} == blen - 6'd1) begin
                    rx_push = rx_en;
                    if ({1'b0, q.wordn} == wcnt - 9'd1) begin
                        d.busy = 1'b0;
                        done   = 1'b1;
                        d.sck  = cpol;
                        d.mosi = 1'b0;
                    end else begin
                        d.wordn = q.wordn + 8'd1;
                        d.bitn  = '0;
                        d.txw   = next_word;
                        d.rxw   = '0;
                        tx_pop  = use_tx && !tx_empty;
                        d.mosi  = next_word[pos_of(lsb, blen, 6'd0)];
                        d.sck   = cpol ^ cpha;
                    end
                end else begin
                    d.bitn = q.bitn + 5'd1;
                    d.mosi = q.txw[pos_of(lsb, blen, {1'b0, q.bitn} + 6'd1)];
                    d.sck  = cpol ^ cpha;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_data = q.rxw << (6'd32 - blen);
    assign sck     = q.sck;
    assign mosi    = q.mosi;
    assign busy    = q.busy;

    // R5
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> $past(clk_en));

    // R6
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy && $past(!q.busy) && ($past(cpol) == cpol) |-> q.sck == cpol);

    // R2
    bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> ({1'b0, q.bitn} < blen));
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
    import sfe_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int HALF_DIV   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        sck,
    output logic        mosi,
    output logic        mosi_oe,
    input  logic        miso
);
    regs_t       rg_q, rg_d;
    logic        wr, rd;
    logic        tx_push, tx_pop, tx_empty, tx_full;
    logic        rx_push, rx_pop, rx_empty, rx_full;
    logic [31:0] tx_head, rx_head, rx_word, w1c, setv;
    logic        eng_busy, eng_done;

    assign wr      = bus_en && bus_we;
    assign rd      = bus_en && !bus_we;
    assign tx_push = wr && (addr_e'(bus_addr) == A_TXD);
    assign rx_pop  = rd && (addr_e'(bus_addr) == A_RXD);

    sfe_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(bus_wdata),
        .pop(tx_pop), .head(tx_head), .empty(tx_empty), .full(tx_full));

    sfe_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word),
        .pop(rx_pop), .head(rx_head), .empty(rx_empty), .full(rx_full));

    sfe_shift #(.HALF(HALF_DIV), .MAXW(FIFO_DEPTH)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .clk_en(rg_q.ack[C_CLK]), .fs_en(rg_q.ack[C_FS]),
        .tx_en(rg_q.ack[C_TX]), .rx_en(rg_q.ack[C_RX]),
        .cpol(rg_q.ack[C_CPOL]), .cpha(rg_q.ack[C_CPHA]),
        .lsb(rg_q.fmt[F_LSB]), .mute(rg_q.fmt[F_MUTE]),
        .wlen_m1(rg_q.fmt[28:24]), .wcnt_m1(rg_q.fmt[23:16]),
        .tx_head(tx_head), .tx_empty(tx_empty), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_data(rx_word), .miso(miso),
        .sck(sck), .mosi(mosi), .busy(eng_busy), .done(eng_done));

    always_comb begin
        rg_d     = rg_q;
        w1c      = '0;
        setv     = '0;
        rg_d.ack = rg_q.ctrl;
        if (wr) begin
            case (addr_e'(bus_addr))
                A_FMT:   rg_d.fmt  = bus_wdata;
                A_CTRL:  rg_d.ctrl = bus_wdata & CTRL_MASK;
                A_STAT:  w1c       = bus_wdata & STAT_MASK;
                A_IEN:   rg_d.ien  = bus_wdata & STAT_MASK;
                default: ;
            endcase
        end
        setv[S_TEOF] = eng_done && rg_q.ack[C_TX];
        setv[S_REOF] = eng_done && rg_q.ack[C_RX];
        rg_d.stat    = (rg_q.stat & ~w1c) | setv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        case (addr_e'(bus_addr))
            A_FMT:   bus_rdata = rg_q.fmt;
            A_CTRL:  bus_rdata = rg_q.ack;
            A_STAT:  bus_rdata = rg_q.stat;
            A_IEN:   bus_rdata = rg_q.ien;
            A_RXD:   bus_rdata = rx_empty ? 32'd0 : rx_head;
            default: bus_rdata = 32'd0;
        endcase
    end

    assign irq     = |(rg_q.stat & rg_q.ien);
    assign mosi_oe = !rg_q.fmt[F_3W] || (eng_busy && !rg_q.fmt[F_MUTE]);

    // R9
    teof_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done && rg_q.ack[C_TX] |=> rg_q.stat[S_TEOF]);

    // R12
    rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rg_q.ack[C_RX] && !rx_pop && !rx_full |=> $stable(rx_empty) || !$past(rx_empty));
endmodule

// File: tb/sim_spi_frame_master.sv
module sim_spi_frame_master;
    localparam logic [2:0] AF = 3'd0, AC = 3'd1, AS = 3'd2, AI = 3'd3, AT = 3'd4, AR = 3'd5;
    localparam logic [31:0] CLK_B = 32'h8000, FS_B = 32'h4000, TX_B = 32'h200, RX_B = 32'h100;
    localparam logic [31:0] TEOF = 32'h0080_0000, REOF = 32'h0000_0080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        irq, sck, mosi, mosi_oe, miso;

    int total = 0, bad = 0;

    always #10 clk = ~clk;
    assign miso = mosi;

    spi_frame_master u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sck(sck), .mosi(mosi), .mosi_oe(mosi_oe), .miso(miso));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard and wire monitor
    logic [31:0] exp_q[$];
    logic        mon_on = 1'b0, mon_lsb = 1'b0, mon_cpol = 1'b0, mon_cpha = 1'b0;
    int          mon_len = 8;
    string       mon_req = "R2";
    logic        prev_sck = 1'b0, hit;
    logic [31:0] acc = '0, expw;
    int          nb = 0, sck_edges = 0;
    logic        oe_watch = 1'b0, oe_seen = 1'b0;

    always @(negedge clk) begin
        if (sck != prev_sck) sck_edges++;
        if (oe_watch && mosi_oe) oe_seen = 1'b1;
        if (mon_on) begin
            hit = mon_cpha ? (prev_sck != mon_cpol && sck == mon_cpol)
                           : (prev_sck == mon_cpol && sck != mon_cpol);
            if (hit) begin
                if (mon_lsb) acc[nb] = mosi;
                else         acc = {acc[30:0], mosi};
                nb++;
                if (nb == mon_len) begin
                    if (exp_q.size() == 0) chk(1'b0, mon_req, acc, 32'hx);
                    else begin
                        expw = exp_q.pop_front();
                        chk(acc == expw, mon_req, acc, expw);
                    end
                    acc = '0;
                    nb  = 0;
                end
            end
        end else begin
            acc = '0;
            nb  = 0;
        end
        prev_sck = sck;
    end

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk);
        #1 bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #3 v = bus_rdata;
        @(posedge clk);
        #1 bus_en = 1'b0;
    endtask

    task automatic wait_ack(input logic [31:0] c);
        logic [31:0] v;
        for (int i = 0; i < 8; i++) begin
            bus_rd(AC, v);
            if (v == c) break;
        end
    endtask

    // driver: pushes a word into the transmit queue and the scoreboard
    task automatic push_word(input logic [31:0] val, input int len);
        bus_wr(AT, val << (32 - len));
        exp_q.push_back(val);
    endtask

    task automatic start_frame(input logic [31:0] mode, input bit tx, input bit rx);
        logic [31:0] c;
        c = mode | CLK_B; bus_wr(AC, c); wait_ack(c);
        if (rx) begin c |= RX_B; bus_wr(AC, c); wait_ack(c); end
        if (tx) begin c |= TX_B; bus_wr(AC, c); wait_ack(c); end
        mon_on = 1'b1;
        c |= FS_B; bus_wr(AC, c); wait_ack(c);
    endtask

    task automatic stop_frame(input logic [31:0] mode);
        logic [31:0] c, v;
        bus_rd(AC, v);
        c = v & ~FS_B; bus_wr(AC, c); wait_ack(c);
        mon_on = 1'b0;
        c &= ~TX_B; bus_wr(AC, c); wait_ack(c);
        c &= ~RX_B; bus_wr(AC, c); wait_ack(c);
        c = mode;   bus_wr(AC, c); wait_ack(c);
    endtask

    task automatic wait_irq(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (irq) begin seen = 1'b1; break; end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        bit          seen;
        int          mism;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_rd(AC, v); chk(v == 0, "R1 ctrl", v, 0);
        bus_rd(AS, v); chk(v == 0, "R1 stat", v, 0);
        chk(irq == 0 && sck == 0 && mosi_oe == 1, "R1 pins", {irq, sck, mosi_oe}, 3'b001);

        // R4 acknowledge readback
        bus_wr(AC, CLK_B);
        bus_rd(AC, v);
        bus_rd(AC, v); chk(v == CLK_B, "R4 ack", v, CLK_B);
        bus_wr(AC, 0); wait_ack(0);

        // R2 R3 basic frame, 8 bits x 3, mode 0
        bus_wr(AI, TEOF | REOF);
        bus_wr(AF, (32'd7 << 24) | (32'd2 << 16));
        mon_len = 8; mon_lsb = 0; mon_cpol = 0; mon_cpha = 0; mon_req = "R2";
        push_word(32'hA5, 8); push_word(32'h3C, 8); push_word(32'h81, 8);
        start_frame(0, 1, 1);
        wait_irq(seen); chk(seen, "R10 irq", {31'd0, seen}, 1);
        chk(exp_q.size() == 0, "R2 count", exp_q.size(), 0);
        bus_rd(AS, v); chk(v == (TEOF | REOF), "R9 both", v, TEOF | REOF);
        bus_rd(AR, v); chk(v == 32'hA500_0000, "R3 rx0", v, 32'hA500_0000);
        bus_rd(AR, v); chk(v == 32'h3C00_0000, "R3 rx1", v, 32'h3C00_0000);
        bus_rd(AR, v); chk(v == 32'h8100_0000, "R3 rx2", v, 32'h8100_0000);
        bus_rd(AR, v); chk(v == 0, "R11 empty", v, 0);
        bus_rd(AR, v); chk(v == 0, "R11 empty again", v, 0);
        stop_frame(0);
        bus_wr(AS, TEOF);
        bus_rd(AS, v); chk(v == REOF, "R9 w1c", v, REOF);
        bus_wr(AS, REOF);
        bus_rd(AS, v); chk(v == 0, "R9 w1c2", v, 0);
        chk(irq == 0, "R10 low", irq, 0);

        // R7 R6 12-bit LSB-first, polarity 1 phase 1
        bus_wr(AF, (32'd11 << 24) | (32'd1 << 16) | (32'd1 << 8));
        bus_wr(AC, 32'h3); wait_ack(32'h3);
        repeat (3) @(negedge clk);
        chk(sck == 1, "R6 idle", sck, 1);
        mon_len = 12; mon_lsb = 1; mon_cpol = 1; mon_cpha = 1; mon_req = "R7";
        push_word(32'hABC, 12); push_word(32'h123, 12);
        start_frame(32'h3, 1, 1);
        wait_irq(seen); chk(seen && exp_q.size() == 0, "R7 done", exp_q.size(), 0);
        bus_rd(AR, v); chk(v == 32'hABC0_0000, "R3 rx12a", v, 32'hABC0_0000);
        bus_rd(AR, v); chk(v == 32'h1230_0000, "R3 rx12b", v, 32'h1230_0000);
        stop_frame(32'h3);
        bus_wr(AS, TEOF | REOF);

        // R6 32-bit, polarity 0 phase 1
        bus_wr(AF, (32'd31 << 24));
        mon_len = 32; mon_lsb = 0; mon_cpol = 0; mon_cpha = 1; mon_req = "R6";
        push_word(32'hDEAD_BEEF, 32);
        start_frame(32'h1, 1, 1);
        wait_irq(seen); chk(seen && exp_q.size() == 0, "R6 done", exp_q.size(), 0);
        bus_rd(AR, v); chk(v == 32'hDEAD_BEEF, "R3 rx32", v, 32'hDEAD_BEEF);
        stop_frame(32'h1);
        bus_wr(AS, TEOF | REOF);

        // R9 R12 receive disabled
        bus_wr(AF, (32'd7 << 24));
        mon_len = 8; mon_cpha = 0; mon_req = "R12";
        bus_wr(AI, TEOF);
        push_word(32'h77, 8);
        start_frame(0, 1, 0);
        wait_irq(seen);
        bus_rd(AS, v); chk(v == TEOF, "R9 no rx eof", v, TEOF);
        bus_rd(AR, v); chk(v == 0, "R12 no push", v, 0);
        bus_wr(AI, 0);
        chk(irq == 0, "R10 masked", irq, 0);
        stop_frame(0);
        bus_wr(AS, TEOF | REOF);
        bus_wr(AI, TEOF | REOF);

        // R8 receive-only with three-wire
        bus_wr(AF, (32'd7 << 24) | 32'h201);
        bus_wr(AT, 32'h5A00_0000);
        exp_q.push_back(0); mon_req = "R8";
        @(negedge clk); chk(mosi_oe == 0, "R8 idle oe", mosi_oe, 0);
        oe_seen = 0; oe_watch = 1;
        start_frame(0, 1, 1);
        wait_irq(seen);
        oe_watch = 0;
        chk(!oe_seen, "R8 oe off", oe_seen, 0);
        bus_rd(AR, v); chk(v == 0, "R8 rx zero", v, 0);
        stop_frame(0);
        bus_wr(AS, TEOF | REOF);
        bus_wr(AF, (32'd7 << 24) | 32'h200);
        exp_q.push_back(32'h5A);
        oe_seen = 0; oe_watch = 1;
        start_frame(0, 1, 1);
        wait_irq(seen);
        oe_watch = 0;
        chk(oe_seen, "R8 oe on", oe_seen, 1);
        bus_rd(AR, v); chk(v == 32'h5A00_0000, "R8 not popped", v, 32'h5A00_0000);
        stop_frame(0);
        bus_wr(AS, TEOF | REOF);
        bus_wr(AF, (32'd7 << 24));

        // R5 frame start without clock enable
        begin
            int e0;
            e0 = sck_edges;
            bus_wr(AC, FS_B | TX_B);
            repeat (60) @(negedge clk);
            chk(sck_edges == e0, "R5 no sck", sck_edges - e0, 0);
            bus_rd(AS, v); chk(v == 0, "R5 no status", v, 0);
            bus_wr(AC, 0); wait_ack(0);
        end

        // R11 full transmit queue, 64-word frame
        bus_wr(AF, (32'd7 << 24) | (32'd63 << 16));
        mon_req = "R11";
        for (int i = 0; i < 64; i++) push_word(32'(i + 1), 8);
        bus_wr(AT, 32'hEE00_0000);
        start_frame(0, 1, 1);
        wait_irq(seen);
        chk(seen && exp_q.size() == 0, "R11 64 words", exp_q.size(), 0);
        mism = 0;
        for (int i = 0; i < 64; i++) begin
            bus_rd(AR, v);
            if (v != (32'(i + 1) << 24)) mism++;
        end
        chk(mism == 0, "R11 rx 64", mism, 0);
        bus_rd(AR, v); chk(v == 0, "R11 drained", v, 0);
        stop_frame(0);
        bus_wr(AS, TEOF | REOF);
        bus_wr(AF, (32'd7 << 24));
        exp_q.push_back(0);
        start_frame(0, 1, 1);
        wait_irq(seen);
        chk(seen && exp_q.size() == 0, "R11 dropped word", exp_q.size(), 0);
        bus_rd(AR, v);
        stop_frame(0);
        bus_wr(AS, TEOF | REOF);

        // R9 set and clear in the same cycle
        mon_req = "R9";
        push_word(32'h11, 8);
        start_frame(0, 1, 1);
        seen = 0;
        for (int i = 0; i < 3000; i++) begin
            bus_wr(AS, 32'hFFFF_FFFF);
            #3;
            if (irq) begin seen = 1; break; end
        end
        chk(seen, "R9 set wins", {31'd0, seen}, 1);
        bus_rd(AS, v); chk(v == (TEOF | REOF), "R9 held", v, TEOF | REOF);
        bus_rd(AR, v);
        stop_frame(0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule